// File: doc/BRIEF.md
# Pulsed QPSK Burst Generator

The block builds framed bursts of a four-phase keyed carrier. A free-running 32-bit phase accumulator advances by a tuning word on every clock. Its top ten bits address a sine table that holds one quarter of a wave and rebuilds the rest by mirroring and negation. A two-bit symbol code adds a quarter-turn multiple to the table address, so each symbol starts the carrier at 0°, 90°, 180° or 270° of offset.

Timing comes from two counters that step together. A symbol counter divides the clock into symbol slots. A slot counter, which advances only on symbol boundaries, marks the repetition period, so every burst begins exactly on a slot edge. A burst shows a programmed number of symbols, stays silent for the rest of its period, and repeats a programmed number of times. After the last burst the output stays off. A host loads the settings through a one-cycle write port. The block takes a copy of the settings at the start of each burst, so writes made during a burst never disturb it.

Top module: `qpsk_burst_gen`

## Requirements
- R1: While reset is applied and after it is released, with no start command, `valid_o` is 0 and `sample_o` is 0.
- R2: While `valid_o` is 1, `sample_o` equals round(8191·sin(2π(p+0.5)/1024)), rounded away from zero at halves. Here p = (A[31:22] + 256·c) mod 1024, c is the symbol's code and A is the accumulator. A is 0 after reset and grows by the latched tuning word (address 1) every clock, so in state cycle t after the start edge A = t·TW mod 2^32.
- R3: Symbol k of a burst (k counted from 0) uses code bits [2j+1:2j] of the code word (address 6), with j = k mod 16. Code values 0, 1, 2 and 3 give phase offsets of 0°, 90°, 180° and 270°.
- R4: Each symbol lasts W clocks, where W is the symbol width (address 2, bits 15:0). A value of 0 acts as 1.
- R5: A burst period is P symbol slots (address 4, bits 7:0). The first N slots (address 3, bits 7:0) are shown with `valid_o` = 1 and the rest are off. A value of 0 for N or P acts as 1. If N ≥ P, the output stays on for the whole period.
- R6: A sequence holds B bursts (address 5, bits 7:0; 0 acts as 1), placed back to back at period spacing. After the last burst the output stays off.
- R7: A write to address 0 with bit 0 = 1, taken at clock edge e, starts a sequence. The first valid sample appears after edge e+1.
- R8: A write to address 0 with bit 0 = 0, taken at edge e, ends the sequence. From edge e+2 on, `valid_o` is 0.
- R9: Writes to addresses 1 to 6 do not change the burst in progress. They take effect at the next burst start within the sequence. The burst count is taken only when the sequence starts.
- R10: Whenever `valid_o` is 0, `sample_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 control, 1 tuning, 2 width, 3 symbols, 4 period, 5 bursts, 6 code word) |
| wr_data | input | 32 | Write data |
| sample_o | output | 14 | Signed carrier sample |
| valid_o | output | 1 | High while the output is gated on |

## Verification
The output is one register behind the timing state. State cycle t begins at start edge e+t, and its sample is due after edge e+t+1. A register write taken at edge x acts on state cycle x+1 onward. For each scenario, the bench computes every expected output sample before the start command is issued. Each sample is tagged with the absolute clock count at which it is due. The monitor compares an item only at the negative edge where its tag matches the cycle count, so a sample that is one cycle early or late is reported. Writes made during a burst are placed at known offsets, so each lands before the next burst's boundary edge.

// File: rtl/qbg_pkg.sv
package qbg_pkg;
  localparam int TUNE_W    = 32;
  localparam int CNT_W     = 16;
  localparam int SYM_W     = 8;
  localparam int CODE_SYMS = 16;
  localparam int CODE_W    = 2 * CODE_SYMS;
  localparam int IDX_W     = $clog2(CODE_SYMS);
  localparam int RADDR_W   = 3;
  localparam int RDATA_W   = 32;

  typedef enum logic [RADDR_W-1:0] {
    RA_CTRL   = 3'd0,
    RA_TUNE   = 3'd1,
    RA_WIDTH  = 3'd2,
    RA_NSYM   = 3'd3,
    RA_PERIOD = 3'd4,
    RA_COUNT  = 3'd5,
    RA_CODE   = 3'd6
  } qbg_reg_e;

  typedef struct packed {
    logic [TUNE_W-1:0] tune;
    logic [CNT_W-1:0]  width;
    logic [SYM_W-1:0]  nsym;
    logic [SYM_W-1:0]  period;
    logic [SYM_W-1:0]  bursts;
    logic [CODE_W-1:0] code;
  } qbg_cfg_t;
endpackage

// File: rtl/qbg_rst_sync.sv
module qbg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/qbg_cfg_regs.sv
module qbg_cfg_regs
  import qbg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [RADDR_W-1:0] wr_addr,
  input  logic [RDATA_W-1:0] wr_data,
  output qbg_cfg_t           cfg_o,
  output logic               start_o,
  output logic               stop_o
);
  qbg_cfg_t cfg_q, cfg_d;
  logic     ctrl_hit;

  always_comb begin
    cfg_d = cfg_q;
    case (wr_addr)
      RA_TUNE:   cfg_d.tune   = wr_data[TUNE_W-1:0];
      RA_WIDTH:  cfg_d.width  = wr_data[CNT_W-1:0];
      RA_NSYM:   cfg_d.nsym   = wr_data[SYM_W-1:0];
      RA_PERIOD: cfg_d.period = wr_data[SYM_W-1:0];
      RA_COUNT:  cfg_d.bursts = wr_data[SYM_W-1:0];
      RA_CODE:   cfg_d.code   = wr_data[CODE_W-1:0];
      default:   cfg_d = cfg_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_q <= '0;
    else if (wr_en) cfg_q <= cfg_d;
  end

  assign ctrl_hit = wr_en && (wr_addr == RA_CTRL);
  assign start_o  = ctrl_hit &&  wr_data[0];
  assign stop_o   = ctrl_hit && !wr_data[0];
  assign cfg_o    = cfg_q;
endmodule

// File: rtl/qbg_burst_timer.sv
module qbg_burst_timer
  import qbg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  qbg_cfg_t          cfg_i,
  input  logic              start_i,
  input  logic              stop_i,
  output logic              gate_o,
  output logic [1:0]        code_o,
  output logic [TUNE_W-1:0] tune_o,
  output logic              active_o,
  output logic [CNT_W-1:0]  sym_cnt_o,
  output logic [SYM_W-1:0]  slot_o
);
  logic              act_q, act_d;
  logic [CNT_W-1:0]  sym_q, sym_d, wl_q, wl_d;
  logic [SYM_W-1:0]  slot_q, slot_d, nl_q, nl_d, pl_q, pl_d, left_q, left_d;
  logic [SYM_W-1:0]  slot_inc;
  logic [CODE_W-1:0] cw_q, cw_d;
  logic [TUNE_W-1:0] tune_q, tune_d;
  logic [1:0]        code_q, code_d;
  logic              load;

  function automatic logic [CNT_W-1:0] last_w(input logic [CNT_W-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  function automatic logic [SYM_W-1:0] last_s(input logic [SYM_W-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  function automatic logic [1:0] pick(input logic [CODE_W-1:0] w,
                                      input logic [SYM_W-1:0]  s);
    logic [IDX_W:0] bitpos;
    bitpos = {s[IDX_W-1:0], 1'b0};
    return w[bitpos +: 2];
  endfunction

  assign slot_inc = slot_q + 1'b1;

  always_comb begin
    act_d  = act_q;
    sym_d  = sym_q;
    slot_d = slot_q;
    left_d = left_q;
    wl_d   = wl_q;
    nl_d   = nl_q;
    pl_d   = pl_q;
    cw_d   = cw_q;
    tune_d = tune_q;
    code_d = code_q;
    load   = 1'b0;
    if (start_i) begin
      act_d  = 1'b1;
      left_d = last_s(cfg_i.bursts);
      load   = 1'b1;
    end else if (stop_i) begin
      act_d = 1'b0;
    end else if (act_q) begin
      if (sym_q == wl_q) begin
        sym_d = '0;
        if (slot_q == pl_q) begin
          if (left_q == '0) begin
            act_d = 1'b0;
          end else begin
            left_d = left_q - 1'b1;
            load   = 1'b1;
          end
        end else begin
          slot_d = slot_inc;
          code_d = pick(cw_q, slot_inc);
        end
      end else begin
        sym_d = sym_q + 1'b1;
      end
    end
    if (load) begin
      sym_d  = '0;
      slot_d = '0;
      wl_d   = last_w(cfg_i.width);
      nl_d   = last_s(cfg_i.nsym);
      pl_d   = last_s(cfg_i.period);
      cw_d   = cfg_i.code;
      tune_d = cfg_i.tune;
      code_d = cfg_i.code[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      sym_q  <= '0;
      slot_q <= '0;
      left_q <= '0;
      wl_q   <= '0;
      nl_q   <= '0;
      pl_q   <= '0;
      cw_q   <= '0;
      tune_q <= '0;
      code_q <= '0;
    end else begin
      act_q  <= act_d;
      sym_q  <= sym_d;
      slot_q <= slot_d;
      left_q <= left_d;
      wl_q   <= wl_d;
      nl_q   <= nl_d;
      pl_q   <= pl_d;
      cw_q   <= cw_d;
      tune_q <= tune_d;
      code_q <= code_d;
    end
  end

  assign gate_o    = act_q && (slot_q <= nl_q);
  assign code_o    = code_q;
  assign tune_o    = tune_q;
  assign active_o  = act_q;
  assign sym_cnt_o = sym_q;
  assign slot_o    = slot_q;
endmodule

// File: rtl/qbg_dds.sv
module qbg_dds #(
  parameter int ACC_W    = 32,
  parameter int PHASE_W  = 10,
  parameter int SAMPLE_W = 14
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ACC_W-1:0]           tune_i,
  input  logic                       gate_i,
  input  logic [1:0]                 code_i,
  output logic signed [SAMPLE_W-1:0] sample_o,
  output logic                       valid_o
);
  localparam int  QBITS  = PHASE_W - 2;
  localparam int  QDEPTH = 1 << QBITS;
  localparam real PI     = 3.14159265358979323846;
  localparam real AMP    = real'((1 << (SAMPLE_W - 1)) - 1);

  function automatic int quarter_val(input int i);
    real x;
    x = AMP * $sin(2.0 * PI * (real'(i) + 0.5) / real'(4 * QDEPTH));
    return $rtoi(x + 0.5);
  endfunction

  logic [SAMPLE_W-2:0] rom [QDEPTH];

  for (genvar g = 0; g < QDEPTH; g++) begin : g_rom
    localparam int QV = quarter_val(g);
    assign rom[g] = QV[SAMPLE_W-2:0];
  end

  logic [ACC_W-1:0]           acc_q, acc_d;
  logic [PHASE_W-1:0]         phase;
  logic [1:0]                 quad;
  logic [QBITS-1:0]           idx, idx_m;
  logic signed [SAMPLE_W-1:0] mag_ext, val;
  logic signed [SAMPLE_W-1:0] sample_q, sample_d;
  logic                       valid_q;

  assign acc_d   = acc_q + tune_i;
  assign phase   = acc_q[ACC_W-1 -: PHASE_W] + {code_i, {QBITS{1'b0}}};
  assign quad    = phase[PHASE_W-1 -: 2];
  assign idx     = phase[QBITS-1:0];
  assign idx_m   = quad[0] ? ~idx : idx;
  assign mag_ext = {1'b0, rom[idx_m]};
  assign val     = quad[1] ? -mag_ext : mag_ext;
  assign sample_d = gate_i ? val : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      sample_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      acc_q    <= acc_d;
      sample_q <= sample_d;
      valid_q  <= gate_i;
    end
  end

  assign sample_o = sample_q;
  assign valid_o  = valid_q;
endmodule

// File: rtl/qpsk_burst_gen.sv
module qpsk_burst_gen
  import qbg_pkg::*;
#(
  parameter int PHASE_W  = 10,
  parameter int SAMPLE_W = 14
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [RADDR_W-1:0]         wr_addr,
  input  logic [RDATA_W-1:0]         wr_data,
  output logic signed [SAMPLE_W-1:0] sample_o,
  output logic                       valid_o
);
  logic              rst_s;
  qbg_cfg_t          cfg;
  logic              start, stop, gate, t_active;
  logic [1:0]        t_code;
  logic [TUNE_W-1:0] t_tune;
  logic [CNT_W-1:0]  t_sym_cnt;
  logic [SYM_W-1:0]  t_slot;

  qbg_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s)
  );

  qbg_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_s), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cfg_o(cfg), .start_o(start), .stop_o(stop)
  );

  qbg_burst_timer u_timer (
    .clk(clk), .rst_n(rst_s), .cfg_i(cfg), .start_i(start), .stop_i(stop),
    .gate_o(gate), .code_o(t_code), .tune_o(t_tune), .active_o(t_active),
    .sym_cnt_o(t_sym_cnt), .slot_o(t_slot)
  );

  qbg_dds #(.ACC_W(TUNE_W), .PHASE_W(PHASE_W), .SAMPLE_W(SAMPLE_W)) u_dds (
    .clk(clk), .rst_n(rst_s), .tune_i(t_tune), .gate_i(gate),
    .code_i(t_code), .sample_o(sample_o), .valid_o(valid_o)
  );
endmodule

// File: rtl/qbg_checker.sv
module qbg_checker
  import qbg_pkg::*;
#(
  parameter int SAMPLE_W = 14
) (
  input logic                clk,
  input logic                rst_s,
  input logic                wr_en,
  input logic [RADDR_W-1:0]  wr_addr,
  input logic [RDATA_W-1:0]  wr_data,
  input logic [SAMPLE_W-1:0] sample_o,
  input logic                valid_o,
  input logic                active,
  input logic [CNT_W-1:0]    sym_cnt,
  input logic [SYM_W-1:0]    slot,
  input logic [1:0]          code,
  input logic [TUNE_W-1:0]   tune
);
  p_zero_when_off_r10: assert property (@(posedge clk) disable iff (!rst_s)
    !valid_o |-> (sample_o == '0));

  p_burst_on_boundary_r5: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(valid_o) |-> ($past(sym_cnt) == '0));

  p_code_held_r3: assert property (@(posedge clk) disable iff (!rst_s)
    (active && (sym_cnt != '0)) |-> $stable(code));

  p_tune_held_r9: assert property (@(posedge clk) disable iff (!rst_s)
    (active && !((sym_cnt == '0) && (slot == '0))) |-> $stable(tune));

  p_stop_gates_r8: assert property (@(posedge clk) disable iff (!rst_s)
    (wr_en && (wr_addr == 3'd0) && !wr_data[0]) |=> ##1 !valid_o);

  p_first_valid_r7: assert property (@(posedge clk) disable iff (!rst_s)
    (wr_en && (wr_addr == 3'd0) && wr_data[0]) |=> ##1 valid_o);
endmodule

bind qpsk_burst_gen qbg_checker #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk(clk), .rst_s(rst_s), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .sample_o(sample_o), .valid_o(valid_o),
  .active(t_active), .sym_cnt(t_sym_cnt), .slot(t_slot),
  .code(t_code), .tune(t_tune)
);

// File: tb/tb_qpsk_burst_gen.sv
module tb_qpsk_burst_gen;
  logic               clk;
  logic               rst_n;
  logic               wr_en;
  logic [2:0]         wr_addr;
  logic [31:0]        wr_data;
  logic signed [13:0] sample_o;
  logic               valid_o;

  qpsk_burst_gen dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sample_o(sample_o), .valid_o(valid_o)
  );

  typedef struct {
    longint tag;
    bit     v;
    int     s;
    string  req;
  } item_t;

  item_t  sb[$];
  longint cyc = 0;
  int     checks = 0;
  int     errors = 0;
  bit     done = 0;

  int p_w, p_n0, p_n1, p_p, p_b, p_stop;
  logic [31:0] p_c0, p_c1, p_tw;

  initial clk = 0;
  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int sine_ref(input int addr);
    real x;
    x = 8191.0 * $sin(2.0 * 3.14159265358979323846 * (real'(addr) + 0.5) / 1024.0);
    if (x >= 0.0) return $rtoi(x + 0.5);
    return -$rtoi(-x + 0.5);
  endfunction

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic item_t predict(input int t, input longint base, input string req);
    item_t it;
    int we, pe, be, s, b, k, nb, code, addr;
    logic [31:0] cw, a;
    we = eff(p_w); pe = eff(p_p); be = eff(p_b);
    s = t / we; b = s / pe; k = s % pe;
    nb = eff((b == 0) ? p_n0 : p_n1);
    cw = (b == 0) ? p_c0 : p_c1;
    it.v = (b < be) && (k < nb) && !(p_stop >= 0 && t >= p_stop + 1);
    code = int'((cw >> (2 * (k % 16))) & 32'd3);
    a = 32'(t) * p_tw;
    addr = (int'(a >> 22) + code * 256) % 1024;
    it.s = it.v ? sine_ref(addr) : 0;
    it.tag = base + 2 + t;
    it.req = req;
    return it;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic direct_check(input string req);
    checks++;
    if (valid_o !== 1'b0 || sample_o !== 14'sd0) begin
      errors++;
      $display("FAIL %s: valid=%0b sample=%0d expected valid=0 sample=0", req, valid_o, sample_o);
    end
  endtask

  task automatic do_reset;
    wr_en = 0; wr_addr = 0; wr_data = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    direct_check("R1 in reset");
    rst_n = 1;
    repeat (4) @(negedge clk);
    direct_check("R1 after reset");
  endtask

  task automatic run_case(input int w, input int n0, input int p, input int b,
                          input logic [31:0] c0, input logic [31:0] tw,
                          input int chg_x, input int n1, input logic [31:0] c1,
                          input int stop_x, input int len, input string req);
    longint base;
    do_reset();
    p_w = w; p_n0 = n0; p_p = p; p_b = b; p_c0 = c0; p_tw = tw;
    p_n1 = (chg_x >= 0) ? n1 : n0;
    p_c1 = (chg_x >= 0) ? c1 : c0;
    p_stop = stop_x;
    wr(3'd1, tw);
    wr(3'd2, 32'(w));
    wr(3'd3, 32'(n0));
    wr(3'd4, 32'(p));
    wr(3'd5, 32'(b));
    wr(3'd6, c0);
    base = cyc;
    for (int t = 0; t < len; t++) sb.push_back(predict(t, base, req));
    wr(3'd0, 32'd1);
    for (int x = 0; x < len + 2; x++) begin
      wr_en = 0;
      if (x == chg_x)     begin wr_en = 1; wr_addr = 3'd3; wr_data = 32'(n1); end
      if (x == chg_x + 1 && chg_x >= 0) begin wr_en = 1; wr_addr = 3'd6; wr_data = c1; end
      if (x == stop_x)    begin wr_en = 1; wr_addr = 3'd0; wr_data = 32'd0; end
      @(negedge clk);
    end
    wr_en = 0;
    while (sb.size() != 0) @(negedge clk);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      while (sb.size() > 0 && sb[0].tag <= cyc) begin
        it = sb.pop_front();
        checks++;
        if (it.tag != cyc) begin
          errors++;
          $display("FAIL %s: item for cycle %0d missed, now %0d expected %0d", it.req, it.tag, cyc, it.tag);
        end else if (valid_o !== it.v || int'(sample_o) != it.s) begin
          errors++;
          $display("FAIL %s: cycle %0d valid=%0b sample=%0d expected valid=%0b sample=%0d",
                   it.req, cyc, valid_o, sample_o, it.v, it.s);
        end
      end
    end
  end

  initial begin : watchdog
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : driver
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
    @(negedge clk);
    // R2 R3 R4 R5 R6 R7 R10: four symbols, period six, two bursts, codes 0..3
    run_case(4, 4, 6, 2, 32'h0000_00E4, 32'h0100_0000, -1, 0, 0, -1, 56,
             "R2 R3 R4 R5 R6 R7 R10");
    // R4 R5 R6: width zero acts as one, N larger than P keeps output on
    run_case(0, 5, 3, 3, 32'h0000_001B, 32'h0123_4567, -1, 0, 0, -1, 15,
             "R4 R5 R6");
    // R9: symbol count and code word rewritten inside the first burst
    run_case(3, 2, 4, 3, 32'h0000_0039, 32'h0200_0000, 3, 4, 32'h0000_00C6, -1, 42,
             "R9");
    // R8 R10: stop command in the middle of a sequence
    run_case(2, 3, 4, 5, 32'h0000_002D, 32'h0080_0000, -1, 0, 0, 9, 30,
             "R8 R10");
    // R3: more than sixteen symbols wrap around the code word
    run_case(1, 20, 20, 1, 32'h8D2B_71E4, 32'h0040_0000, -1, 0, 0, -1, 26,
             "R3");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule